// File: doc/BRIEF.md
# SPI NOR Flash Read Emulator

This block is the target side of a serial NOR flash stand-in. A host controller drives chip select, clock and up to four data lines as it would for a real flash part. The block decodes the opcode, takes a 24-bit address over one, two or four lines, counts the mode/dummy clocks, and then streams bytes back over one, two or four lines. It also answers an identification command with a three-byte vendor/device code and a status command with a status byte. Both values come in on input ports.

Read data lives in an external backing memory that returns 8-byte bursts a fixed number of system clocks after a one-cycle request. To hide that latency, the block requests the first burst as soon as address bit 3 has arrived. During streaming it requests the following burst once the shifter reaches a byte late in the current one. Which byte that is depends on how many data lines are in use. All bus pins are oversampled in the system clock domain through two-stage synchronizers. A run input, when low, holds the whole block in reset so that it stays silent on the bus.

Top module: `spi_nor_emu`

## Requirements
- R1: While `run` is low (or `rst_n` is low) the block drives no data line (`io_oe` = 0), issues no memory request and reports no completion. After `run` returns high, the next transaction behaves normally.
- R2: Opcode 0x03 takes the 24-bit address MSB first on `io_in[0]` with no dummy clocks. It then returns data MSB first on `io_out[1]`. Byte k (0..7) of a returned burst is `mem_rdata[8k+7:8k]`.
- R3: Opcodes 0x0B, 0x3B and 0x6B take the address on `io_in[0]`, then 8 dummy clocks. They return data on 1 line (`io_out[1]`), 2 lines (`io_out[1:0]`, IO1 the more significant) or 4 lines (`io_out[3:0]`, IO3 the most significant) respectively.
- R4: Opcode 0xBB takes the address two bits per clock on `io_in[1:0]` (IO1 the more significant), ignores 4 mode/dummy clocks, and returns data on two lines.
- R5: Opcode 0xEB takes the address four bits per clock on `io_in[3:0]`, ignores 6 mode/dummy clocks, and returns data on four lines.
- R6: Opcode 0x9F returns `jedec_id[23:16]`, `[15:8]`, `[7:0]` in that order on `io_out[1]`, repeating while clocks continue. Opcode 0x05 returns `status_reg` on every byte.
- R7: The first burst request is issued after the rising SCK edge that captures address bit 3 and before the next rising edge. `mem_addr` carries the address bits `[SIZE_LOG2-1:3]`.
- R8: During streaming, exactly one request for the following burst is made per burst. It is issued when the first byte whose index within its burst is at least 7 (single-line data) or at least 6 (dual or quad data) starts shifting out.
- R9: A read continues through consecutive addresses across burst boundaries until chip select rises. Addresses wrap modulo 2^`SIZE_LOG2`, and address bits above that are ignored.
- R10: When chip select rises after a read reached its data phase, `done_pulse` is high for one cycle and `byte_count` holds the number of complete bytes sent.
- R11: An unrecognised opcode leaves all data lines undriven and makes no request until chip select rises. The next transaction is decoded normally.
- R12: Inputs are sampled on SCK rising edges and outputs change only after SCK falling edges. `io_oe` enables exactly the data lanes of the current command from the first data falling edge until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Low holds the block in reset (emulation stopped) |
| sck | input | 1 | Serial clock from the bus controller (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Sampled data lines IO3..IO0 |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Per-line output enable; 0 means tri-stated |
| jedec_id | input | 24 | Identification bytes, most significant sent first |
| status_reg | input | 8 | Value returned by the status command |
| mem_req | output | 1 | One-cycle backing memory burst request |
| mem_addr | output | SIZE_LOG2-3 | Burst address (byte address / 8) |
| mem_rvalid | input | 1 | Burst data valid, one cycle |
| mem_rdata | input | 64 | Burst data, byte k in bits [8k+7:8k] |
| done_pulse | output | 1 | One-cycle end-of-read indication |
| byte_count | output | COUNT_W | Complete bytes sent by the last read |

## Verification
A wrong phase or bit counter shows up on the first data byte after the address, as a byte shifted by whole bits or taken from the wrong lane. A bad dummy count shows up the same way. A stale or misrouted burst buffer only shows up at the first burst boundary, so every read crosses at least one boundary and starts at all eight offsets within a burst. The prefetch schedule is observed at the request port itself: both the SCK edge number of the first request and the number of requests per transaction are compared. A slip there would otherwise stay hidden until the backing latency grew.

// File: rtl/spi_nor_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the serial NOR read emulator.
// Assumes lane counts are encoded as log2 (0 = one line, 1 = two, 2 = four).
package spi_nor_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_ID,
        K_STAT
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [1:0] addr_lg;
        logic [3:0] dummy;
        logic [1:0] data_lg;
    } cmd_attr_t;

    localparam logic [7:0] OP_RD_SLOW  = 8'h03;
    localparam logic [7:0] OP_RD_FAST  = 8'h0B;
    localparam logic [7:0] OP_RD_DOUT  = 8'h3B;
    localparam logic [7:0] OP_RD_QOUT  = 8'h6B;
    localparam logic [7:0] OP_RD_DIO   = 8'hBB;
    localparam logic [7:0] OP_RD_QIO   = 8'hEB;
    localparam logic [7:0] OP_IDENT    = 8'h9F;
    localparam logic [7:0] OP_STATUS   = 8'h05;

    // Number of lines for a log2 lane code.
    function automatic logic [2:0] lane_width(input logic [1:0] lg);
        case (lg)
            2'd0:    lane_width = 3'd1;
            2'd1:    lane_width = 3'd2;
            default: lane_width = 3'd4;
        endcase
    endfunction

    // Output-enable pattern for a log2 lane code.
    function automatic logic [3:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    lane_mask = 4'b0010;
            2'd1:    lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    // Place the top bits of a byte onto the pins for a lane code.
    function automatic logic [3:0] lane_bits(input logic [7:0] b, input logic [1:0] lg);
        case (lg)
            2'd0:    lane_bits = {2'b00, b[7], 1'b0};
            2'd1:    lane_bits = {2'b00, b[7:6]};
            default: lane_bits = b[7:4];
        endcase
    endfunction

endpackage

// File: rtl/spi_nor_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a bundle of asynchronous bus pins.
// Assumes all bits may be sampled independently; RST_VAL is the idle level.
module spi_nor_sync #(
    parameter int          W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_nor_cmd_decode.sv
`timescale 1ns/1ps
// Opcode decoder: maps a received opcode to its address lanes, dummy clock
// count, data lanes and kind. Purely combinational.
module spi_nor_cmd_decode
    import spi_nor_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_attr_t  attr
);
    // Table of supported commands; anything else is ignored.
    always_comb begin
        attr = '{kind: K_NONE, addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
        case (opcode)
            OP_RD_SLOW: attr = '{kind: K_READ, addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
            OP_RD_FAST: attr = '{kind: K_READ, addr_lg: 2'd0, dummy: 4'd8, data_lg: 2'd0};
            OP_RD_DOUT: attr = '{kind: K_READ, addr_lg: 2'd0, dummy: 4'd8, data_lg: 2'd1};
            OP_RD_QOUT: attr = '{kind: K_READ, addr_lg: 2'd0, dummy: 4'd8, data_lg: 2'd2};
            OP_RD_DIO:  attr = '{kind: K_READ, addr_lg: 2'd1, dummy: 4'd4, data_lg: 2'd1};
            OP_RD_QIO:  attr = '{kind: K_READ, addr_lg: 2'd2, dummy: 4'd6, data_lg: 2'd2};
            OP_IDENT:   attr = '{kind: K_ID,   addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
            OP_STATUS:  attr = '{kind: K_STAT, addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
            default:    attr = '{kind: K_NONE, addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
        endcase
    end
endmodule

// File: rtl/spi_nor_fetch.sv
`timescale 1ns/1ps
// Burst prefetcher: holds the burst being shifted and the one after it,
// tracks the current byte address and issues one-cycle burst requests.
// Assumes at most one request is outstanding and that the memory latency
// is shorter than the headroom the schedule leaves.
module spi_nor_fetch #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic          start,
    input  logic [AW-4:0] start_burst,
    input  logic          set_low,
    input  logic [2:0]    low,
    input  logic          load,
    input  logic [2:0]    trig_idx,
    output logic [7:0]    byte_o,
    output logic          mem_req,
    output logic [AW-4:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata
);
    logic [AW-1:0] rd_addr;
    logic [63:0]   cur_buf;
    logic [63:0]   nxt_buf;
    logic          nxt_reqd;
    logic          fill_nxt;
    logic          first;
    logic [2:0]    idx;
    logic          sel_nxt;
    logic [63:0]   word;

    // Select the byte at the current address, from the next burst on a boundary.
    always_comb begin
        idx     = rd_addr[2:0];
        sel_nxt = !first && (idx == 3'd0);
        word    = sel_nxt ? nxt_buf : cur_buf;
        byte_o  = word[{idx, 3'b000} +: 8];
    end

    // Address tracking, buffer rotation, fill routing and request issue.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            rd_addr  <= '0;
            cur_buf  <= '0;
            nxt_buf  <= '0;
            nxt_reqd <= 1'b0;
            fill_nxt <= 1'b0;
            first    <= 1'b1;
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_req <= 1'b0;
            if (mem_rvalid) begin
                if (fill_nxt) nxt_buf <= mem_rdata;
                else          cur_buf <= mem_rdata;
            end
            if (clear) begin
                first    <= 1'b1;
                nxt_reqd <= 1'b0;
            end else begin
                if (start) begin
                    rd_addr[AW-1:3] <= start_burst;
                    mem_req         <= 1'b1;
                    mem_addr        <= start_burst;
                    fill_nxt        <= 1'b0;
                end
                if (set_low) rd_addr[2:0] <= low;
                if (load) begin
                    first   <= 1'b0;
                    rd_addr <= rd_addr + 1'b1;
                    if (sel_nxt) begin
                        cur_buf  <= nxt_buf;
                        nxt_reqd <= 1'b0;
                    end
                    if (idx >= trig_idx && !nxt_reqd) begin
                        mem_req  <= 1'b1;
                        mem_addr <= rd_addr[AW-1:3] + 1'b1;
                        fill_nxt <= 1'b1;
                        nxt_reqd <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_nor_emu.sv
`timescale 1ns/1ps
// Serial NOR flash read emulator, target side. Oversamples the bus in the
// clk domain, decodes the opcode, gathers the address, counts dummy clocks
// and shifts data out on 1, 2 or 4 lines from a prefetched burst buffer.
// Assumes SPI mode 0 and an SCK half period of at least 4 clk cycles.
module spi_nor_emu
    import spi_nor_pkg::*;
#(
    parameter int SIZE_LOG2 = 24,
    parameter int COUNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic [3:0]           io_in,
    output logic [3:0]           io_out,
    output logic [3:0]           io_oe,
    input  logic [23:0]          jedec_id,
    input  logic [7:0]           status_reg,
    output logic                 mem_req,
    output logic [SIZE_LOG2-4:0] mem_addr,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata,
    output logic                 done_pulse,
    output logic [COUNT_W-1:0]   byte_count
);
    localparam int BURST_AW = SIZE_LOG2 - 3;
    localparam logic [4:0] BIT3_POS = 5'd21;
    localparam logic [4:0] ADDR_BITS = 5'd24;

    logic       sck_s, cs_s, sck_d, cs_d;
    logic [3:0] io_s;
    logic       sck_rise, sck_fall, cs_rise_ev, active;

    spi_nor_sync #(.W(6), .RST_VAL(6'b010000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck, cs_n, io_in}),
        .q    ({sck_s, cs_s, io_s})
    );

    phase_t      phase;
    cmd_attr_t   attr, attr_dec;
    logic [6:0]  op_sh;
    logic [2:0]  op_cnt;
    logic [4:0]  a_cnt;
    logic [23:0] addr_sh;
    logic [3:0]  dum_cnt;
    logic [7:0]  out_sh;
    logic [3:0]  out_left;
    logic [3:0]  rx_bits;
    logic [COUNT_W-1:0] bytes_sent;
    logic [1:0]  id_idx;

    logic [23:0] addr_next, bit3_aligned;
    logic [4:0]  nb;
    logic [2:0]  a_w, d_w;
    logic        f_start, f_setlow, f_load;
    logic [7:0]  fetch_byte, src_byte;
    logic [2:0]  trig_idx;

    spi_nor_cmd_decode u_dec (
        .opcode({op_sh, io_s[0]}),
        .attr  (attr_dec)
    );

    // Edge detection on the synchronized clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    // Address assembly, fetch control strobes and data source selection.
    always_comb begin
        sck_rise   = sck_s & ~sck_d;
        sck_fall   = ~sck_s & sck_d;
        cs_rise_ev = cs_s & ~cs_d;
        active     = run & ~cs_s;
        a_w        = lane_width(attr.addr_lg);
        d_w        = lane_width(attr.data_lg);
        case (attr.addr_lg)
            2'd0:    addr_next = {addr_sh[22:0], io_s[0]};
            2'd1:    addr_next = {addr_sh[21:0], io_s[1:0]};
            default: addr_next = {addr_sh[19:0], io_s[3:0]};
        endcase
        nb           = a_cnt + {2'b00, a_w};
        bit3_aligned = addr_next >> (nb - BIT3_POS);
        f_start  = active && sck_rise && phase == PH_ADDR && a_cnt < BIT3_POS && nb >= BIT3_POS;
        f_setlow = active && sck_rise && phase == PH_ADDR && nb == ADDR_BITS;
        f_load   = active && sck_fall && phase == PH_DATA && out_left == 4'd0 && attr.kind == K_READ;
        trig_idx = (attr.data_lg == 2'd0) ? 3'd7 : 3'd6;
        case (attr.kind)
            K_READ: src_byte = fetch_byte;
            K_ID: begin
                case (id_idx)
                    2'd0:    src_byte = jedec_id[23:16];
                    2'd1:    src_byte = jedec_id[15:8];
                    default: src_byte = jedec_id[7:0];
                endcase
            end
            K_STAT:  src_byte = status_reg;
            default: src_byte = 8'hFF;
        endcase
    end

    spi_nor_fetch #(.AW(SIZE_LOG2)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .clear      (cs_s),
        .start      (f_start),
        .start_burst(bit3_aligned[BURST_AW-1:0]),
        .set_low    (f_setlow),
        .low        (addr_next[2:0]),
        .load       (f_load),
        .trig_idx   (trig_idx),
        .byte_o     (fetch_byte),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    // Transaction state machine: opcode, address, dummy and data phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase      <= PH_CMD;
            attr       <= '{kind: K_NONE, addr_lg: 2'd0, dummy: 4'd0, data_lg: 2'd0};
            op_sh      <= '0;
            op_cnt     <= '0;
            a_cnt      <= '0;
            addr_sh    <= '0;
            dum_cnt    <= '0;
            out_sh     <= '0;
            out_left   <= '0;
            rx_bits    <= '0;
            bytes_sent <= '0;
            id_idx     <= '0;
            io_out     <= '0;
            io_oe      <= '0;
        end else if (cs_s) begin
            phase      <= PH_CMD;
            op_cnt     <= '0;
            a_cnt      <= '0;
            dum_cnt    <= '0;
            out_left   <= '0;
            rx_bits    <= '0;
            bytes_sent <= '0;
            id_idx     <= '0;
            io_oe      <= '0;
        end else if (sck_rise) begin
            case (phase)
                PH_CMD: begin
                    op_sh  <= {op_sh[5:0], io_s[0]};
                    op_cnt <= op_cnt + 1'b1;
                    if (op_cnt == 3'd7) begin
                        attr <= attr_dec;
                        case (attr_dec.kind)
                            K_READ:      phase <= PH_ADDR;
                            K_ID, K_STAT: phase <= PH_DATA;
                            default:     phase <= PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    addr_sh <= addr_next;
                    a_cnt   <= nb;
                    if (nb == ADDR_BITS)
                        phase <= (attr.dummy == 4'd0) ? PH_DATA : PH_DUMMY;
                end
                PH_DUMMY: begin
                    dum_cnt <= dum_cnt + 1'b1;
                    if (dum_cnt == attr.dummy - 4'd1) phase <= PH_DATA;
                end
                PH_DATA: begin
                    if (rx_bits + {1'b0, d_w} == 4'd8) begin
                        rx_bits <= '0;
                        if (attr.kind == K_READ) bytes_sent <= bytes_sent + 1'b1;
                    end else begin
                        rx_bits <= rx_bits + {1'b0, d_w};
                    end
                end
                default: ;
            endcase
        end else if (sck_fall && phase == PH_DATA) begin
            io_oe <= lane_mask(attr.data_lg);
            if (out_left == 4'd0) begin
                io_out   <= lane_bits(src_byte, attr.data_lg);
                out_sh   <= src_byte << d_w;
                out_left <= 4'd8 - {1'b0, d_w};
                id_idx   <= (id_idx == 2'd2) ? 2'd0 : id_idx + 1'b1;
            end else begin
                io_out   <= lane_bits(out_sh, attr.data_lg);
                out_sh   <= out_sh << d_w;
                out_left <= out_left - {1'b0, d_w};
            end
        end
    end

    // End-of-read report on the chip select rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            done_pulse <= 1'b0;
            byte_count <= '0;
        end else begin
            done_pulse <= 1'b0;
            if (cs_rise_ev && phase == PH_DATA && attr.kind == K_READ) begin
                done_pulse <= 1'b1;
                byte_count <= bytes_sent;
            end
        end
    end
endmodule

// File: rtl/spi_nor_emu_checker.sv
`timescale 1ns/1ps
// Protocol checker for spi_nor_emu, attached by bind. Observes the ports
// and the synchronized select and detected falling edge of the clock.
module spi_nor_emu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       cs_s,
    input logic       sck_fall,
    input logic [3:0] io_out,
    input logic [3:0] io_oe,
    input logic       mem_req,
    input logic       done_pulse
);
    // Stopped block is silent one cycle later.
    assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (io_oe == 4'b0000 && !mem_req && !done_pulse));

    // Enabled lanes always form one of the three legal lane groups.
    assert_lane_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe == 4'b0000 || io_oe == 4'b0010 || io_oe == 4'b0011 || io_oe == 4'b1111);

    // Output values move only after a detected falling SCK edge.
    assert_out_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sck_fall) |=> $stable(io_out));

    // Lines are released while the chip is deselected.
    assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> io_oe == 4'b0000);

    // Requests are single-cycle strobes.
    assert_req_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // Requests only occur inside a selected transaction.
    assert_req_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cs_s);

    // Completion indication is a single-cycle pulse.
    assert_done_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

bind spi_nor_emu spi_nor_emu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cs_s      (cs_s),
    .sck_fall  (sck_fall),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .mem_req   (mem_req),
    .done_pulse(done_pulse)
);

// File: tb/spi_nor_emu_test.sv
`timescale 1ns/1ps
// Bench: drives the bus as a mode-0 controller, models a fixed-latency
// burst memory with arithmetic content and sweeps every read command over
// all start offsets within a burst, plus wrap, ID, status, unknown, stop.
module spi_nor_emu_test;
    localparam int SZ  = 12;
    localparam int CW  = 16;
    localparam int HP  = 4;
    localparam int LAT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b1;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic [3:0]    io_in = 4'h0;
    logic [3:0]    io_out, io_oe;
    logic [23:0]   jedec_id = 24'hC24017;
    logic [7:0]    status_reg = 8'h5A;
    logic          mem_req;
    logic [SZ-4:0] mem_addr;
    logic          mem_rvalid;
    logic [63:0]   mem_rdata;
    logic          done_pulse;
    logic [CW-1:0] byte_count;

    int vectors = 0;
    int fails   = 0;
    int rises   = 0;

    always #2 clk = ~clk;

    spi_nor_emu #(.SIZE_LOG2(SZ), .COUNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .sck(sck), .cs_n(cs_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .jedec_id(jedec_id), .status_reg(status_reg),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done_pulse(done_pulse), .byte_count(byte_count)
    );

    function automatic logic [7:0] byte_at(input int a);
        int m;
        m = a & ((1 << SZ) - 1);
        return 8'((m * 7) + ((m >> 5) * 3) + 8'h5C);
    endfunction

    function automatic logic [63:0] burst_word(input int b);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) w[8*k +: 8] = byte_at(b * 8 + k);
        return w;
    endfunction

    // Backing memory: fixed latency pipeline.
    logic [LAT-1:0] pv = '0;
    logic [SZ-4:0]  pa [LAT];
    always @(posedge clk) begin
        pv    <= {pv[LAT-2:0], mem_req};
        pa[0] <= mem_addr;
        for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
    end
    assign mem_rvalid = pv[LAT-1];
    assign mem_rdata  = burst_word(int'(pa[LAT-1]));

    // Request and completion logging per transaction.
    int          tx_reqs = 0;
    logic        f_seen = 1'b0;
    int          f_addr = 0;
    int          f_rise = 0;
    logic        d_seen = 1'b0;
    int          d_cnt = 0;
    always @(posedge clk) begin
        if (cs_n) begin
            tx_reqs <= 0;
            f_seen  <= 1'b0;
        end else if (mem_req) begin
            tx_reqs <= tx_reqs + 1;
            if (!f_seen) begin
                f_seen <= 1'b1;
                f_addr <= int'(mem_addr);
                f_rise <= rises;
            end
        end
        if (!cs_n) d_seen <= 1'b0;
        else if (done_pulse) begin
            d_seen <= 1'b1;
            d_cnt  <= int'(byte_count);
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sclk(input logic [3:0] d, output logic [3:0] q, output logic [3:0] qoe);
        io_in = d;
        repeat (HP) @(negedge clk);
        q   = io_out;
        qoe = io_oe;
        sck = 1'b1;
        rises++;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [3:0] q, qoe;
        cs_n  = 1'b0;
        rises = 0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) sclk({3'b000, op[i]}, q, qoe);
    endtask

    task automatic end_tx();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] op, input int a, input int n, input string tag);
        int alg, dlg, dm, aw, dw, trig, exp_req, lastb, val;
        logic [3:0] q, qoe, msk;
        case (op)
            8'h03:   begin alg = 0; dm = 0; dlg = 0; end
            8'h0B:   begin alg = 0; dm = 8; dlg = 0; end
            8'h3B:   begin alg = 0; dm = 8; dlg = 1; end
            8'h6B:   begin alg = 0; dm = 8; dlg = 2; end
            8'hBB:   begin alg = 1; dm = 4; dlg = 1; end
            default: begin alg = 2; dm = 6; dlg = 2; end
        endcase
        aw  = 1 << alg;
        dw  = 1 << dlg;
        msk = (dw == 1) ? 4'b0010 : (dw == 2) ? 4'b0011 : 4'b1111;
        send_op(op);
        for (int c = 0; c < 24 / aw; c++)
            sclk(4'((a >> (24 - aw * (c + 1))) & ((1 << aw) - 1)), q, qoe);
        for (int c = 0; c < dm; c++) sclk(4'h0, q, qoe);
        for (int b = 0; b < n; b++) begin
            val = 0;
            for (int c = 0; c < 8 / dw; c++) begin
                sclk(4'h0, q, qoe);
                if (dw == 1)      val = (val << 1) | int'(q[1]);
                else if (dw == 2) val = (val << 2) | int'(q[1:0]);
                else              val = (val << 4) | int'(q);
                // R12: only the command's lanes enabled during data
                if (c == 0) check(qoe == msk, "R12 lanes", int'(qoe), int'(msk));
            end
            check(val == int'(byte_at(a + b)), tag, val, int'(byte_at(a + b)));
        end
        repeat (HP) @(negedge clk);
        // R8: one follow-on request per burst that reaches the trigger byte
        trig    = (dw == 1) ? 7 : 6;
        exp_req = 1;
        lastb   = -1;
        for (int x = a; x <= a + n; x++)
            if ((x & 7) >= trig && (x >> 3) != lastb) begin
                exp_req++;
                lastb = x >> 3;
            end
        check(tx_reqs == exp_req, "R8 request count", tx_reqs, exp_req);
        // R7: first request address and the rising edge that triggered it
        check(f_addr == ((a & ((1 << SZ) - 1)) >> 3), "R7 first burst", f_addr, (a & ((1 << SZ) - 1)) >> 3);
        check(f_rise == 8 + (21 + aw - 1) / aw, "R7 first request edge", f_rise, 8 + (21 + aw - 1) / aw);
        end_tx();
        // R10: completion count
        check(d_seen && d_cnt == n, "R10 byte count", d_cnt, n);
    endtask

    task automatic quiet_tx(input logic [7:0] op, input int nclk, input string tag);
        logic [3:0] q, qoe;
        send_op(op);
        for (int c = 0; c < nclk; c++) begin
            sclk(4'(c * 5 + 3), q, qoe);
            check(qoe == 4'h0, tag, int'(qoe), 0);
        end
        repeat (HP) @(negedge clk);
        check(tx_reqs == 0, tag, tx_reqs, 0);
        end_tx();
        check(!d_seen, tag, int'(d_seen), 0);
    endtask

    task automatic single_bytes(input logic [7:0] op, input int n, input string tag);
        logic [3:0] q, qoe;
        int val;
        logic [7:0] exp;
        send_op(op);
        for (int b = 0; b < n; b++) begin
            val = 0;
            for (int c = 0; c < 8; c++) begin
                sclk(4'h0, q, qoe);
                val = (val << 1) | int'(q[1]);
            end
            if (op == 8'h05) exp = status_reg;
            else exp = (b % 3 == 0) ? jedec_id[23:16] : (b % 3 == 1) ? jedec_id[15:8] : jedec_id[7:0];
            check(val == int'(exp), tag, val, int'(exp));
        end
        repeat (HP) @(negedge clk);
        check(tx_reqs == 0, tag, tx_reqs, 0);
        end_tx();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] ops [6];
        string      tags [6];
        ops[0] = 8'h03; tags[0] = "R2 data";
        ops[1] = 8'h0B; tags[1] = "R3 data";
        ops[2] = 8'h3B; tags[2] = "R3 data";
        ops[3] = 8'h6B; tags[3] = "R3 data";
        ops[4] = 8'hBB; tags[4] = "R4 data";
        ops[5] = 8'hEB; tags[5] = "R5 data";
        repeat (5) @(negedge clk);
        // R1: reset state
        check(io_oe == 4'h0, "R1 reset oe", int'(io_oe), 0);
        check(!mem_req, "R1 reset req", int'(mem_req), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(io_oe == 4'h0 && !done_pulse, "R1 idle", int'(io_oe), 0);

        // Every read command at every offset within a burst.
        for (int o = 0; o < 6; o++)
            for (int off = 0; off < 8; off++)
                do_read(ops[o], 24'h240 + off * 9, 18, tags[o]);

        // R9: wrap at the top of the space and ignored upper address bits.
        do_read(8'h03, 24'h000FFB, 14, "R9 wrap single");
        do_read(8'hEB, 24'h000FFD, 12, "R9 wrap quad");
        do_read(8'h6B, 24'hABCFF9, 12, "R9 upper bits");

        // R6: identification and status.
        single_bytes(8'h9F, 7, "R6 ident");
        single_bytes(8'h05, 3, "R6 status");

        // R11: unknown opcode, then normal decoding.
        quiet_tx(8'h5A, 20, "R11 unknown");
        do_read(8'h0B, 24'h000123, 5, "R11 after unknown");

        // R1: stopped block stays silent, then recovers.
        run = 1'b0;
        quiet_tx(8'h03, 40, "R1 stopped");
        run = 1'b1;
        repeat (5) @(negedge clk);
        do_read(8'h3B, 24'h000777, 9, "R1 after restart");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule